// File: doc/BRIEF.md
# Vector Control and Status Register Bank

This block holds the control and status registers of a processor's vector unit. It answers single-cycle software register requests, each addressed by a 12-bit register index. A read request returns the stored value. A write request returns a flag that rejects writes to read-only registers. Every response is combinational in the cycle of the request, and accepted writes take effect at the next rising clock edge. Each writable register keeps only its legal bits, so software can never store a value the hardware does not support.

The fixed-point saturation flag and the rounding mode each have one physical home. The combined fixed-point register is formed from those same two fields, so the three views always agree, and a write through any of them shows at once in the others. A separate update port lets the vector configuration logic load the vector length and vector type registers, which software cannot write. Two datapath strobes are also provided: one sets the saturation flag and one clears the start-element index. No privilege gating is applied, because every register in the bank is open to user-level code.

Top module: `vcr_bank`

## Requirements
- R1: After reset, vstart, vl, the saturation flag and the rounding mode read 0, vtype reads with only its top bit (bit XLEN-1) set, and vlenb reads VLEN/8.
- R2: A read of a recognised index (vstart 0x008, vxsat 0x009, vxrm 0x00A, vcsr 0x00F, vl 0xC20, vtype 0xC21, vlenb 0xC22) raises the claim flag, returns the stored value, and changes no state.
- R3: A request to any other index drops the claim flag, returns zero read data, raises no error, and leaves all state unchanged, even when it is a write.
- R4: A write to vl, vtype or vlenb raises the read-only error for that request and changes no state.
- R5: A write to vxsat stores data bit 0 only. Afterwards vcsr bit 0 equals that bit and vcsr bits 2:1 are unchanged.
- R6: A write to vxrm stores data bits 1:0 only. Afterwards vcsr bits 2:1 equal them and vcsr bit 0 is unchanged.
- R7: A write to vcsr stores data bits 2:0 only. Afterwards vxsat reads bit 0 and vxrm reads bits 2:1 of the written value.
- R8: A write to vstart stores the smaller of the full write value and VSTART_MAX (65535 by default).
- R9: A one-cycle saturation strobe sets the saturation flag to 1. A software write to vxsat or vcsr in the same cycle takes priority over the strobe.
- R10: A one-cycle vstart clear strobe sets vstart to 0. A software write to vstart in the same cycle takes priority over the strobe.
- R11: A configuration load strobe stores its vl and vtype inputs, which read back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Software request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_index | input | 12 | Register index |
| req_wdata | input | XLEN | Write data |
| rsp_rdata | output | XLEN | Read data for the current request |
| rsp_claimed | output | 1 | Index belongs to this bank |
| rsp_ro_err | output | 1 | Write to a read-only register was rejected |
| cfg_load | input | 1 | Load vl and vtype from the configuration port |
| cfg_vl | input | XLEN | New vector length |
| cfg_vtype | input | XLEN | New vector type |
| sat_set | input | 1 | Datapath saturation event |
| vstart_clear | input | 1 | Datapath request to zero vstart |

## Verification
The bench writes through each alias in turn and reads the result back through the other views. A design that held vcsr as its own copy would show stale bits after a vxsat or vxrm write. A design that rebuilt vcsr without masking would let a wide write leak ones into the upper bits. The bench writes to vstart both above and below the ceiling, which catches a design that truncates or wraps instead of clamping. It issues rejected writes to the read-only registers and to an unknown index, and checks both the flags and the stored state afterwards. Finally it pairs each datapath strobe with a software write in the same cycle, which exposes a design with the priority reversed.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    localparam logic [11:0] IDX_VSTART = 12'h008;
    localparam logic [11:0] IDX_VXSAT  = 12'h009;
    localparam logic [11:0] IDX_VXRM   = 12'h00A;
    localparam logic [11:0] IDX_VCSR   = 12'h00F;
    localparam logic [11:0] IDX_VL     = 12'hC20;
    localparam logic [11:0] IDX_VTYPE  = 12'hC21;
    localparam logic [11:0] IDX_VLENB  = 12'hC22;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VSTART,
        SEL_VXSAT,
        SEL_VXRM,
        SEL_VCSR,
        SEL_VL,
        SEL_VTYPE,
        SEL_VLENB
    } vcr_sel_e;

    // Saturation flag and rounding mode: the one physical copy behind three views
    typedef struct packed {
        logic       sat;
        logic [1:0] rnd;
    } fxp_state_t;

endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
    import vcr_pkg::*;
(
    input  logic [11:0] index,
    output vcr_sel_e    sel,
    output logic        read_only
);

    always_comb begin
        sel = SEL_NONE;
        case (index)
            IDX_VSTART: sel = SEL_VSTART;
            IDX_VXSAT:  sel = SEL_VXSAT;
            IDX_VXRM:   sel = SEL_VXRM;
            IDX_VCSR:   sel = SEL_VCSR;
            IDX_VL:     sel = SEL_VL;
            IDX_VTYPE:  sel = SEL_VTYPE;
            IDX_VLENB:  sel = SEL_VLENB;
            default:    sel = SEL_NONE;
        endcase
    end

    always_comb begin
        read_only = (sel == SEL_VL) || (sel == SEL_VTYPE) || (sel == SEL_VLENB);
    end

endmodule

// File: rtl/vcr_fxp.sv
module vcr_fxp
    import vcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sat,
    input  logic       wr_rnd,
    input  logic       wr_comb,
    input  logic [2:0] wdata,
    input  logic       sat_set,
    output logic       sat,
    output logic [1:0] rnd
);

    fxp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Datapath event first, so a software write in the same cycle overrides it
        if (sat_set) begin
            state_d.sat = 1'b1;
        end
        if (wr_sat) begin
            state_d.sat = wdata[0];
        end
        if (wr_rnd) begin
            state_d.rnd = wdata[1:0];
        end
        if (wr_comb) begin
            state_d.sat = wdata[0];
            state_d.rnd = wdata[2:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sat = state_q.sat;
    assign rnd = state_q.rnd;

endmodule

// File: rtl/vcr_cfg.sv
module vcr_cfg #(
    parameter int XLEN       = 64,
    parameter int VSTART_MAX = 65535
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_vstart,
    input  logic [XLEN-1:0]     wdata,
    input  logic                vstart_clear,
    input  logic                cfg_load,
    input  logic [XLEN-1:0]     cfg_vl,
    input  logic [XLEN-1:0]     cfg_vtype,
    output logic [XLEN-1:0]     vstart,
    output logic [XLEN-1:0]     vl,
    output logic [XLEN-1:0]     vtype
);

    localparam int VS_W = $clog2(VSTART_MAX + 1);
    localparam logic [XLEN-1:0] CEIL = XLEN'(VSTART_MAX);
    localparam logic [XLEN-1:0] VTYPE_RST = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        logic [VS_W-1:0] vstart;
        logic [XLEN-1:0] vl;
        logic [XLEN-1:0] vtype;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    logic [VS_W-1:0] clamped;

    always_comb begin
        clamped = (wdata > CEIL) ? VS_W'(VSTART_MAX) : wdata[VS_W-1:0];
    end

    always_comb begin
        state_d = state_q;
        if (vstart_clear) begin
            state_d.vstart = '0;
        end
        if (wr_vstart) begin
            state_d.vstart = clamped;
        end
        if (cfg_load) begin
            state_d.vl    = cfg_vl;
            state_d.vtype = cfg_vtype;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.vstart <= '0;
            state_q.vl     <= '0;
            state_q.vtype  <= VTYPE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign vstart = XLEN'(state_q.vstart);
    assign vl     = state_q.vl;
    assign vtype  = state_q.vtype;

endmodule

// File: rtl/vcr_bank.sv
module vcr_bank
    import vcr_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int VLEN       = 128,
    parameter int VSTART_MAX = 65535
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [11:0]     req_index,
    input  logic [XLEN-1:0] req_wdata,
    output logic [XLEN-1:0] rsp_rdata,
    output logic            rsp_claimed,
    output logic            rsp_ro_err,
    input  logic            cfg_load,
    input  logic [XLEN-1:0] cfg_vl,
    input  logic [XLEN-1:0] cfg_vtype,
    input  logic            sat_set,
    input  logic            vstart_clear
);

    localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);

    vcr_sel_e        sel;
    logic            read_only;
    logic            wr_ok;
    logic            sat_q;
    logic [1:0]      rnd_q;
    logic [XLEN-1:0] vstart_q;
    logic [XLEN-1:0] vl_q;
    logic [XLEN-1:0] vtype_q;

    vcr_decode u_decode (
        .index     (req_index),
        .sel       (sel),
        .read_only (read_only)
    );

    assign wr_ok = req_valid && req_write && !read_only;

    vcr_fxp u_fxp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sat  (wr_ok && (sel == SEL_VXSAT)),
        .wr_rnd  (wr_ok && (sel == SEL_VXRM)),
        .wr_comb (wr_ok && (sel == SEL_VCSR)),
        .wdata   (req_wdata[2:0]),
        .sat_set (sat_set),
        .sat     (sat_q),
        .rnd     (rnd_q)
    );

    vcr_cfg #(
        .XLEN       (XLEN),
        .VSTART_MAX (VSTART_MAX)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_vstart    (wr_ok && (sel == SEL_VSTART)),
        .wdata        (req_wdata),
        .vstart_clear (vstart_clear),
        .cfg_load     (cfg_load),
        .cfg_vl       (cfg_vl),
        .cfg_vtype    (cfg_vtype),
        .vstart       (vstart_q),
        .vl           (vl_q),
        .vtype        (vtype_q)
    );

    always_comb begin
        rsp_rdata = '0;
        if (req_valid) begin
            case (sel)
                SEL_VSTART: rsp_rdata = vstart_q;
                SEL_VXSAT:  rsp_rdata = XLEN'(sat_q);
                SEL_VXRM:   rsp_rdata = XLEN'(rnd_q);
                SEL_VCSR:   rsp_rdata = XLEN'({rnd_q, sat_q});
                SEL_VL:     rsp_rdata = vl_q;
                SEL_VTYPE:  rsp_rdata = vtype_q;
                SEL_VLENB:  rsp_rdata = VLENB_VAL;
                default:    rsp_rdata = '0;
            endcase
        end
    end

    assign rsp_claimed = req_valid && (sel != SEL_NONE);
    assign rsp_ro_err  = req_valid && req_write && read_only;

endmodule

// File: rtl/vcr_bank_chk.sv
module vcr_bank_chk
    import vcr_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int VSTART_MAX = 65535
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [11:0]     req_index,
    input logic [XLEN-1:0] req_wdata,
    input logic            rsp_claimed,
    input logic            rsp_ro_err,
    input logic            cfg_load,
    input logic [XLEN-1:0] cfg_vl,
    input logic            sat_set,
    input logic            sat_q,
    input logic [1:0]      rnd_q,
    input logic [XLEN-1:0] vstart_q,
    input logic [XLEN-1:0] vl_q,
    input logic [XLEN-1:0] vtype_q
);

    logic ro_wr;
    logic sw_sat_wr;
    assign ro_wr = req_valid && req_write &&
                   (req_index == IDX_VL || req_index == IDX_VTYPE || req_index == IDX_VLENB);
    assign sw_sat_wr = req_valid && req_write && (req_index == IDX_VXSAT || req_index == IDX_VCSR);

    AST_RO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) ro_wr |-> rsp_ro_err); // R4
    AST_RO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_wr && !cfg_load) |=> ($stable(vl_q) && $stable(vtype_q))); // R4
    AST_UNCLAIMED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_claimed) |-> !rsp_ro_err); // R3
    AST_VXSAT_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_index == IDX_VXSAT) |=> (sat_q == $past(req_wdata[0]) && $stable(rnd_q))); // R5
    AST_VXRM_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_index == IDX_VXRM && !sat_set) |=> (rnd_q == $past(req_wdata[1:0]) && $stable(sat_q))); // R6
    AST_VCSR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_index == IDX_VCSR) |=> ({rnd_q, sat_q} == $past(req_wdata[2:0]))); // R7
    AST_VSTART_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        vstart_q <= XLEN'(VSTART_MAX)); // R8
    AST_SAT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_set && !sw_sat_wr) |=> sat_q); // R9
    AST_CFG_LOAD_VL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (vl_q == $past(cfg_vl))); // R11

endmodule

bind vcr_bank vcr_bank_chk #(
    .XLEN       (XLEN),
    .VSTART_MAX (VSTART_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_index   (req_index),
    .req_wdata   (req_wdata),
    .rsp_claimed (rsp_claimed),
    .rsp_ro_err  (rsp_ro_err),
    .cfg_load    (cfg_load),
    .cfg_vl      (cfg_vl),
    .sat_set     (sat_set),
    .sat_q       (sat_q),
    .rnd_q       (rnd_q),
    .vstart_q    (vstart_q),
    .vl_q        (vl_q),
    .vtype_q     (vtype_q)
);

// File: tb/tb_vcr_bank.sv
`timescale 1ns/1ps
module tb_vcr_bank;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_index = '0;
    logic [XLEN-1:0] req_wdata = '0;
    logic [XLEN-1:0] rsp_rdata;
    logic            rsp_claimed;
    logic            rsp_ro_err;
    logic            cfg_load = 1'b0;
    logic [XLEN-1:0] cfg_vl = '0;
    logic [XLEN-1:0] cfg_vtype = '0;
    logic            sat_set = 1'b0;
    logic            vstart_clear = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vcr_bank #(.XLEN(XLEN), .VLEN(128), .VSTART_MAX(65535)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_claimed(rsp_claimed), .rsp_ro_err(rsp_ro_err), .cfg_load(cfg_load),
        .cfg_vl(cfg_vl), .cfg_vtype(cfg_vtype), .sat_set(sat_set),
        .vstart_clear(vstart_clear)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] idx;
        logic [63:0] wd;
        logic        cl;
        logic        er;
        logic [11:0] cidx;
        logic [63:0] cval;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h009, 64'hFF,    1'b1, 1'b0, 12'h009, 64'h1,    8'd5}, // R5 vxsat keeps bit 0
        '{1'b0, 12'h00F, 64'h0,     1'b1, 1'b0, 12'h00F, 64'h1,    8'd5}, // R5 vcsr bit 0 view
        '{1'b1, 12'h00A, 64'hFE,    1'b1, 1'b0, 12'h00F, 64'h5,    8'd6}, // R6 vxrm into vcsr 2:1
        '{1'b1, 12'h00F, 64'h1FA,   1'b1, 1'b0, 12'h009, 64'h0,    8'd7}, // R7 vcsr bit 0 to vxsat
        '{1'b0, 12'h00A, 64'h0,     1'b1, 1'b0, 12'h00A, 64'h1,    8'd7}, // R7 vcsr bits 2:1 to vxrm
        '{1'b1, 12'h008, 64'h12345, 1'b1, 1'b0, 12'h008, 64'hFFFF, 8'd8}, // R8 clamp
        '{1'b1, 12'h008, 64'h1234,  1'b1, 1'b0, 12'h008, 64'h1234, 8'd8}, // R8 below ceiling
        '{1'b1, 12'hC20, 64'h5,     1'b1, 1'b1, 12'hC20, 64'h0,    8'd4}, // R4 vl
        '{1'b1, 12'hC21, 64'h0,     1'b1, 1'b1, 12'hC21, 64'h8000_0000_0000_0000, 8'd4}, // R4 vtype
        '{1'b1, 12'hC22, 64'h0,     1'b1, 1'b1, 12'hC22, 64'h10,   8'd4}, // R4 vlenb
        '{1'b1, 12'h00B, 64'h3,     1'b0, 1'b0, 12'h00A, 64'h1,    8'd3}, // R3 unknown write
        '{1'b0, 12'hC23, 64'h0,     1'b0, 1'b0, 12'h00F, 64'h2,    8'd3}  // R3 unknown read
    };

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input int rq, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; sat_set = 1'b0;
        vstart_clear = 1'b0; cfg_load = 1'b0;
    endtask

    // Drive a request at the falling edge and return the combinational response
    task automatic issue(input logic wr, input logic [11:0] idx, input logic [63:0] wd,
                         output logic [63:0] rd, output logic cl, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd;
        #1;
        rd = rsp_rdata; cl = rsp_claimed; er = rsp_ro_err;
    endtask

    task automatic rdreg(input logic [11:0] idx, output logic [63:0] val);
        logic c, e;
        issue(1'b0, idx, 64'h0, val, c, e);
    endtask

    initial begin : watchdog
        #500_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] v, v2;
        logic c, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rdreg(12'h008, v); chk(v, 64'h0, 1, "vstart reset");
        rdreg(12'h009, v); chk(v, 64'h0, 1, "vxsat reset");
        rdreg(12'h00A, v); chk(v, 64'h0, 1, "vxrm reset");
        rdreg(12'hC20, v); chk(v, 64'h0, 1, "vl reset");
        rdreg(12'hC21, v); chk(v, 64'h8000_0000_0000_0000, 1, "vtype reset");
        rdreg(12'hC22, v); chk(v, 64'h10, 1, "vlenb value");

        // Vector table
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].wr, VECS[i].idx, VECS[i].wd, v, c, e);
            chk({63'b0, c}, {63'b0, VECS[i].cl}, int'(VECS[i].rq), "claimed");
            chk({63'b0, e}, {63'b0, VECS[i].er}, int'(VECS[i].rq), "ro error");
            if (!VECS[i].cl) chk(v, 64'h0, int'(VECS[i].rq), "unclaimed rdata");
            rdreg(VECS[i].cidx, v);
            chk(v, VECS[i].cval, int'(VECS[i].rq), "readback");
        end

        // R2 read has no side effect and is claimed
        issue(1'b0, 12'h008, 64'h0, v, c, e);
        chk({63'b0, c}, 64'h1, 2, "read claimed");
        rdreg(12'h008, v2);
        chk(v2, v, 2, "repeat read stable");
        chk(v, 64'h1234, 2, "read value");

        // R9 saturation strobe alone
        issue(1'b1, 12'h009, 64'h0, v, c, e);
        idle();
        sat_set = 1'b1;
        idle();
        rdreg(12'h009, v); chk(v, 64'h1, 9, "strobe sets vxsat");
        // R9 software write wins over strobe
        issue(1'b1, 12'h00F, 64'h0, v, c, e);
        sat_set = 1'b1;
        idle();
        rdreg(12'h009, v); chk(v, 64'h0, 9, "sw write beats strobe");

        // R10 vstart clear strobe
        issue(1'b1, 12'h008, 64'h7, v, c, e);
        idle();
        vstart_clear = 1'b1;
        idle();
        rdreg(12'h008, v); chk(v, 64'h0, 10, "clear strobe");
        issue(1'b1, 12'h008, 64'h9, v, c, e);
        vstart_clear = 1'b1;
        idle();
        rdreg(12'h008, v); chk(v, 64'h9, 10, "sw write beats clear");

        // R11 configuration load
        idle();
        cfg_load = 1'b1; cfg_vl = 64'd12; cfg_vtype = 64'h42;
        idle();
        rdreg(12'hC20, v); chk(v, 64'd12, 11, "vl loaded");
        rdreg(12'hC21, v); chk(v, 64'h42, 11, "vtype loaded");

        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule